// File: doc/BRIEF.md
# Convolutional-Hadamard Component Encoder

This block turns a stream of message sub-blocks into signed Hadamard codewords, one sub-block per clock. Each sub-block is R bits wide. The block first reduces the sub-block to one even-parity bit. That bit goes through a two-state recursive systematic accumulator, whose coded output is the parity bit XOR the previous coded bit. The R data bits and the coded bit together pick one column of the order-R Hadamard matrix and the sign applied to it. The result is a codeword of 2^R bits, where a 0 bit stands for +1 and a 1 bit stands for -1.

A message of L = R·K bits is presented as K consecutive sub-blocks. The caller marks the first sub-block with `in_first`, which clears the accumulator state, and the final one with `in_last`. The full codeword appears one cycle after the input. Beside it, a narrower parity-only view leaves out the R data positions, because the data bits are sent once across all the component encoders that share the message.

Top module: `chad_enc`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `out_valid`, `out_last` and `out_word` are zero. The accumulator state is also zero, so a sub-block accepted right after reset without `in_first` is encoded with a zero seed.
- R2: `out_valid` is high in the cycle after each clock edge where `in_valid` was high, and low otherwise (latency of one cycle).
- R3: Codeword bit 0 carries the coded bit: the XOR of all R data bits, XOR the accumulator state.
- R4: Codeword bit 2^b (b = 0 to R-1) equals data bit b of the same sub-block.
- R5: Every codeword equals column j of the Hadamard matrix with sign s applied: bit i = parity(i AND j) XOR s. Here s is the coded bit and j is the data XOR s replicated over R bits.
- R6: After each accepted sub-block, the accumulator state becomes that sub-block's coded bit, so consecutive sub-blocks chain.
- R7: When `in_valid` is low, neither the accumulator state nor `out_word` changes.
- R8: `out_last` is high exactly in the output cycle of a sub-block accepted with `in_last` high.
- R9: `out_parity` holds the codeword bits at all positions that are not powers of two (position 0 included), in ascending position order from its LSB, and has width 2^R − R.
- R10: A sub-block accepted with `in_first` high is encoded with a zero accumulator state, whatever the state was before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sub-block present on `in_data` |
| in_first | input | 1 | Sub-block opens a frame; seeds the accumulator with zero |
| in_last | input | 1 | Sub-block closes a frame |
| in_data | input | R | Message sub-block |
| out_valid | output | 1 | Codeword valid |
| out_last | output | 1 | Codeword belongs to the closing sub-block |
| out_word | output | 2^R | Signed Hadamard codeword, bit i for position i |
| out_parity | output | 2^R − R | Codeword without the data positions |

## Verification
The properties assume that `in_first` and `in_last` are only meaningful alongside `in_valid`, and that `in_data` is a known value whenever `in_valid` is high. The chaining property looks only at back-to-back accepted sub-blocks, where the previous coded bit is still visible on `out_word[0]`. Gaps with `in_valid` low are covered by the hold property instead. The stimulus raises the framing flags only together with a valid sub-block, drives known data on every cycle, and mixes back-to-back runs, idle gaps, frame restarts and a reset in mid-stream.

// File: rtl/chad_enc.sv
module chad_enc #(
  parameter int R = 7,
  localparam int N = 1 << R,
  localparam int NP = N - R
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [R-1:0]  in_data,
  output logic          out_valid,
  output logic          out_last,
  output logic [N-1:0]  out_word,
  output logic [NP-1:0] out_parity
);

  function automatic int kept_pos(input int k);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 0; p < N; p++) begin
      if (!(p != 0 && (p & (p - 1)) == 0)) begin
        if (cnt == k) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  logic trel_q;
  logic spc_bit;
  logic seed;
  logic coded;
  logic [N-1:0] word_c;

  assign spc_bit = ^in_data;
  assign seed    = in_first ? 1'b0 : trel_q;
  assign coded   = spc_bit ^ seed;

  for (genvar i = 0; i < N; i++) begin : g_row
    localparam logic [R-1:0] ROWSEL = R'(i);
    localparam logic ODDW = ^ROWSEL;
    assign word_c[i] = (^(in_data & ROWSEL)) ^ (coded & ~ODDW);
  end

  for (genvar k = 0; k < NP; k++) begin : g_keep
    localparam int POS = kept_pos(k);
    assign out_parity[k] = out_word[POS];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trel_q    <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      out_last  <= in_valid & in_last;
      if (in_valid) begin
        trel_q   <= coded;
        out_word <= word_c;
      end
    end
  end

endmodule

// File: rtl/chad_enc_chk.sv
module chad_enc_chk #(
  parameter int R = 7,
  localparam int N = 1 << R,
  localparam int NP = N - R
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_first,
  input logic          in_last,
  input logic [R-1:0]  in_data,
  input logic          out_valid,
  input logic          out_last,
  input logic [N-1:0]  out_word,
  input logic [NP-1:0] out_parity
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R8
  AST_LAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> out_last); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word)); // R7
  AST_FIRST_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first) |=> out_word[0] == ^$past(in_data)); // R10
  AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first && out_valid) |=>
      out_word[0] == ((^$past(in_data)) ^ $past(out_word[0]))); // R6
  AST_PARITY_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    out_parity[1] == out_word[3]); // R9

  for (genvar b = 0; b < R; b++) begin : g_info
    AST_INFO_POS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_word[1 << b] == $past(in_data[b])); // R4
  end

endmodule

bind chad_enc chad_enc_chk #(.R(R)) u_chk (.*);

// File: tb/chad_enc_test.sv
module chad_enc_test;
  localparam int R = 7;
  localparam int N = 1 << R;
  localparam int NP = N - R;
  localparam int NV = 12;

  // {valid, first, last, expected coded bit, data}
  localparam logic [R+3:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 7'h00},
    {1'b1, 1'b0, 1'b0, 1'b1, 7'h01},
    {1'b1, 1'b0, 1'b0, 1'b1, 7'h03},
    {1'b0, 1'b0, 1'b0, 1'b1, 7'h7f},
    {1'b1, 1'b0, 1'b0, 1'b0, 7'h7f},
    {1'b1, 1'b0, 1'b1, 1'b0, 7'h55},
    {1'b1, 1'b1, 1'b0, 1'b1, 7'h2a},
    {1'b1, 1'b0, 1'b0, 1'b0, 7'h10},
    {1'b1, 1'b0, 1'b0, 1'b1, 7'h40},
    {1'b1, 1'b1, 1'b0, 1'b0, 7'h00},
    {1'b1, 1'b0, 1'b0, 1'b0, 7'h06},
    {1'b1, 1'b0, 1'b1, 1'b1, 7'h07}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_first = 1'b0;
  logic in_last = 1'b0;
  logic [R-1:0] in_data = '0;
  logic out_valid;
  logic out_last;
  logic [N-1:0] out_word;
  logic [NP-1:0] out_parity;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chad_enc #(.R(R)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .out_valid(out_valid),
    .out_last(out_last), .out_word(out_word), .out_parity(out_parity)
  );

  function automatic logic [N-1:0] hadamard(input logic [R-1:0] d, input logic s);
    logic [N-1:0] w;
    logic [R-1:0] col;
    col = d ^ {R{s}};
    for (int i = 0; i < N; i++) begin
      logic [R-1:0] iv;
      iv = R'(i);
      w[i] = (^(iv & col)) ^ s;
    end
    return w;
  endfunction

  function automatic logic [NP-1:0] strip(input logic [N-1:0] w);
    logic [NP-1:0] p;
    int k;
    k = 0;
    p = '0;
    for (int i = 0; i < N; i++) begin
      if (!(i != 0 && (i & (i - 1)) == 0)) begin
        p[k] = w[i];
        k++;
      end
    end
    return p;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic f, input logic l, input logic [R-1:0] d);
    in_valid = v;
    in_first = f;
    in_last  = l;
    in_data  = d;
    @(negedge clk);
  endtask

  initial begin
    #(5 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] prev_word;
    @(negedge clk);
    @(negedge clk);
    check("R1 valid in reset", N'(out_valid), '0);
    check("R1 last in reset", N'(out_last), '0);
    check("R1 word in reset", out_word, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", N'(out_valid), '0);
    prev_word = out_word;

    for (int v = 0; v < NV; v++) begin
      logic vv, ff, ll, qq;
      logic [R-1:0] dd;
      {vv, ff, ll, qq, dd} = VEC[v];
      apply(vv, ff, ll, dd);
      check("R2 valid", N'(out_valid), N'(vv));
      check("R8 last", N'(out_last), N'(vv & ll));
      if (vv) begin
        check("R3 coded bit", N'(out_word[0]), N'(qq));
        for (int b = 0; b < R; b++)
          check("R4 info position", N'(out_word[1 << b]), N'(dd[b]));
        check("R5 signed column", out_word, hadamard(dd, qq));
        check("R9 parity view", N'(out_parity), N'(strip(hadamard(dd, qq))));
        prev_word = out_word;
      end else begin
        check("R7 word held", out_word, prev_word);
      end
    end

    // R6: chaining across an idle gap (state 1 after last vector)
    apply(1'b0, 1'b0, 1'b0, 7'h33);
    check("R7 idle gap hold", out_word, prev_word);
    apply(1'b1, 1'b0, 1'b0, 7'h00);
    check("R6 chain after gap", out_word, hadamard(7'h00, 1'b1));

    // R10: in_first overrides a state of one
    apply(1'b1, 1'b0, 1'b0, 7'h01);
    check("R6 state set", N'(out_word[0]), N'(1'b0));
    apply(1'b1, 1'b0, 1'b0, 7'h01);
    check("R6 state toggles", N'(out_word[0]), N'(1'b1));
    apply(1'b1, 1'b1, 1'b1, 7'h7e);
    check("R10 first clears state", out_word, hadamard(7'h7e, 1'b0));
    check("R8 single-block frame", N'(out_last), N'(1'b1));

    // R1: reset in mid-stream clears the state
    apply(1'b1, 1'b0, 1'b0, 7'h01);
    rst_n = 1'b0;
    apply(1'b0, 1'b0, 1'b0, 7'h00);
    check("R1 word cleared", out_word, '0);
    check("R1 valid cleared", N'(out_valid), '0);
    rst_n = 1'b1;
    apply(1'b1, 1'b0, 1'b0, 7'h01);
    check("R1 zero seed after reset", out_word, hadamard(7'h01, 1'b1));
    apply(1'b0, 1'b0, 1'b0, 7'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule